// File: doc/BRIEF.md
# Flag Register with Bit-Addressable Logic

This block holds a 32-bit flag register. It is organised as eight groups of four flags. Within a group, the four flags record less-than, greater-than, equal and summary-overflow from a comparison. Execution logic can write a whole group from a compare result, or copy one group into another. It can also combine any two single flags with a two-input logic function and put the result in any third flag. The full word can be loaded and read at any time.

Each request port has its own enable. At most one change is applied per clock. When requests collide, a fixed priority chooses which one is applied. All updates take effect at the rising clock edge. The read port shows the registered word.

Top module: `cond_reg`

## Requirements
- R1: A synchronous active-high `rst` clears all 32 bits to zero.
- R2: `all_wr_en` loads all 32 bits from `all_wr_data`. `cr_q` always presents the whole register.
- R3: Flag index i (0..31) sits at vector position 31-i. Group g covers indices 4g..4g+3, and a group value occupies `cr_q[31-4g -: 4]`. Within a group, its bit 3 is offset 0 (less-than), bit 2 is greater-than, bit 1 is equal and bit 0 is summary-overflow. So group 7's equal flag is index 30, which is `cr_q[1]`.
- R4: `fld_wr_en` replaces group `fld_wr_sel` with `fld_wr_flags` and leaves the other 28 bits unchanged.
- R5: `op_en` with `op_code` 0=AND, 1=OR, 2=XOR, 3=NOR, 4=XNOR, 5=A AND NOT B, 6=A OR NOT B combines flags `op_src_a` and `op_src_b`. The result goes to flag `op_dst`, and every other bit stays unchanged.
- R6: `op_code` 7 is a no-operation, and the register keeps its value.
- R7: Operands are read before the update, even when a source is also the destination. With all three indices equal, XNOR sets the flag, XOR clears it, NOR inverts it, and OR with A=B copies flag A into D.
- R8: `cp_en` copies group `cp_src` into group `cp_dst` and leaves the other groups unchanged. When `cp_src` equals `cp_dst`, nothing changes.
- R9: When requests coincide, only one is applied. Full write beats group write, group write beats group copy, and group copy beats the bit operation.
- R10: With no enable asserted, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| all_wr_en | input | 1 | Full-word load request |
| all_wr_data | input | 32 | Word to load |
| fld_wr_en | input | 1 | Group write request |
| fld_wr_sel | input | 3 | Group to write |
| fld_wr_flags | input | 4 | Flags for the group (bit 3 = less-than) |
| cp_en | input | 1 | Group copy request |
| cp_src | input | 3 | Source group |
| cp_dst | input | 3 | Destination group |
| op_en | input | 1 | Single-bit logic request |
| op_code | input | 3 | Logic function select |
| op_src_a | input | 5 | Flag index of operand A |
| op_src_b | input | 5 | Flag index of operand B |
| op_dst | input | 5 | Flag index of the result |
| cr_q | output | 32 | Current register contents |

## Verification
Every kind of update has one register between request and result. A request presented before a rising edge shows on `cr_q` just after that edge. The bench drives requests on the falling edge and removes them on the next falling edge. It reads `cr_q` at that second falling edge, half a period after the commit. Each bit-logic vector first preloads a known word with a full write and then applies the operation. The check compares the whole word, so any change to a bit other than the destination is caught. Priority and no-operation cases are checked in the same cycle-after way.

// File: rtl/cond_reg_pkg.sv
package cond_reg_pkg;

    parameter int NUM_FIELDS = 8;
    parameter int FIELD_W    = 4;

    localparam int CR_W    = NUM_FIELDS * FIELD_W;
    localparam int BIT_IW  = $clog2(CR_W);
    localparam int FLD_IW  = $clog2(NUM_FIELDS);

    typedef enum logic [2:0] {
        LOP_AND  = 3'd0,
        LOP_OR   = 3'd1,
        LOP_XOR  = 3'd2,
        LOP_NOR  = 3'd3,
        LOP_XNOR = 3'd4,
        LOP_ANDC = 3'd5,
        LOP_ORC  = 3'd6,
        LOP_NOP  = 3'd7
    } lop_e;

    typedef enum logic [2:0] {
        UPD_NONE,
        UPD_ALL,
        UPD_FIELD,
        UPD_COPY,
        UPD_BIT
    } upd_sel_e;

    typedef struct packed {
        logic [CR_W-1:0] word;
    } cr_state_t;

endpackage

// File: rtl/cr_arbiter.sv
module cr_arbiter
    import cond_reg_pkg::*;
(
    input  logic     req_all,
    input  logic     req_field,
    input  logic     req_copy,
    input  logic     req_bit,
    output upd_sel_e sel
);

    // Fixed priority: full load, group write, group copy, bit logic.
    always_comb begin
        if (req_all) begin
            sel = UPD_ALL;
        end else if (req_field) begin
            sel = UPD_FIELD;
        end else if (req_copy) begin
            sel = UPD_COPY;
        end else if (req_bit) begin
            sel = UPD_BIT;
        end else begin
            sel = UPD_NONE;
        end
    end

endmodule

// File: rtl/cr_bit_alu.sv
module cr_bit_alu
    import cond_reg_pkg::*;
(
    input  lop_e op,
    input  logic a,
    input  logic b,
    output logic y,
    output logic valid
);

    always_comb begin
        valid = 1'b1;
        unique case (op)
            LOP_AND:  y = a & b;
            LOP_OR:   y = a | b;
            LOP_XOR:  y = a ^ b;
            LOP_NOR:  y = ~(a | b);
            LOP_XNOR: y = ~(a ^ b);
            LOP_ANDC: y = a & ~b;
            LOP_ORC:  y = a | ~b;
            default: begin
                y     = 1'b0;
                valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cr_field_unit.sv
module cr_field_unit
    import cond_reg_pkg::*;
(
    input  logic [CR_W-1:0]    cur,
    input  logic [FLD_IW-1:0]  wr_sel,
    input  logic [FIELD_W-1:0] wr_flags,
    input  logic [FLD_IW-1:0]  cp_src,
    input  logic [FLD_IW-1:0]  cp_dst,
    output logic [CR_W-1:0]    wr_next,
    output logic [CR_W-1:0]    cp_next
);

    logic [FIELD_W-1:0] grp [NUM_FIELDS];
    logic [FIELD_W-1:0] src_grp;

    // Group g lives at the top end for g = 0 (big-endian numbering).
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_grp
        localparam int HI = CR_W - 1 - g * FIELD_W;
        assign grp[g] = cur[HI -: FIELD_W];
        assign wr_next[HI -: FIELD_W] =
            (wr_sel == FLD_IW'(g)) ? wr_flags : cur[HI -: FIELD_W];
        assign cp_next[HI -: FIELD_W] =
            (cp_dst == FLD_IW'(g)) ? src_grp : cur[HI -: FIELD_W];
    end

    assign src_grp = grp[cp_src];

endmodule

// File: rtl/cr_bit_unit.sv
module cr_bit_unit
    import cond_reg_pkg::*;
(
    input  logic [CR_W-1:0]   cur,
    input  lop_e              op,
    input  logic [BIT_IW-1:0] idx_a,
    input  logic [BIT_IW-1:0] idx_b,
    input  logic [BIT_IW-1:0] idx_d,
    output logic [CR_W-1:0]   next,
    output logic              valid
);

    localparam logic [BIT_IW-1:0] TOP = BIT_IW'(CR_W - 1);

    logic opnd_a;
    logic opnd_b;
    logic res;

    // Operands come from the current word, before any update.
    assign opnd_a = cur[TOP - idx_a];
    assign opnd_b = cur[TOP - idx_b];

    cr_bit_alu u_alu (
        .op    (op),
        .a     (opnd_a),
        .b     (opnd_b),
        .y     (res),
        .valid (valid)
    );

    for (genvar i = 0; i < CR_W; i++) begin : g_bit
        assign next[i] = (TOP - idx_d == BIT_IW'(i)) ? res : cur[i];
    end

endmodule

// File: rtl/cond_reg.sv
module cond_reg
    import cond_reg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 all_wr_en,
    input  logic [CR_W-1:0]      all_wr_data,
    input  logic                 fld_wr_en,
    input  logic [FLD_IW-1:0]    fld_wr_sel,
    input  logic [FIELD_W-1:0]   fld_wr_flags,
    input  logic                 cp_en,
    input  logic [FLD_IW-1:0]    cp_src,
    input  logic [FLD_IW-1:0]    cp_dst,
    input  logic                 op_en,
    input  logic [2:0]           op_code,
    input  logic [BIT_IW-1:0]    op_src_a,
    input  logic [BIT_IW-1:0]    op_src_b,
    input  logic [BIT_IW-1:0]    op_dst,
    output logic [CR_W-1:0]      cr_q
);

    cr_state_t st_d;
    cr_state_t st_q;

    logic [CR_W-1:0] fld_next;
    logic [CR_W-1:0] cp_next;
    logic [CR_W-1:0] bit_next;
    logic            bit_valid;
    upd_sel_e        sel;

    cr_field_unit u_field (
        .cur      (st_q.word),
        .wr_sel   (fld_wr_sel),
        .wr_flags (fld_wr_flags),
        .cp_src   (cp_src),
        .cp_dst   (cp_dst),
        .wr_next  (fld_next),
        .cp_next  (cp_next)
    );

    cr_bit_unit u_bit (
        .cur   (st_q.word),
        .op    (lop_e'(op_code)),
        .idx_a (op_src_a),
        .idx_b (op_src_b),
        .idx_d (op_dst),
        .next  (bit_next),
        .valid (bit_valid)
    );

    cr_arbiter u_arb (
        .req_all   (all_wr_en),
        .req_field (fld_wr_en),
        .req_copy  (cp_en),
        .req_bit   (op_en & bit_valid),
        .sel       (sel)
    );

    always_comb begin
        st_d = st_q;
        unique case (sel)
            UPD_ALL:   st_d.word = all_wr_data;
            UPD_FIELD: st_d.word = fld_next;
            UPD_COPY:  st_d.word = cp_next;
            UPD_BIT:   st_d.word = bit_next;
            default:   st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cr_q = st_q.word;

endmodule

// File: rtl/cond_reg_checker.sv
module cond_reg_checker
    import cond_reg_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 all_wr_en,
    input logic [CR_W-1:0]      all_wr_data,
    input logic                 fld_wr_en,
    input logic [FLD_IW-1:0]    fld_wr_sel,
    input logic [FIELD_W-1:0]   fld_wr_flags,
    input logic                 cp_en,
    input logic [FLD_IW-1:0]    cp_src,
    input logic [FLD_IW-1:0]    cp_dst,
    input logic                 op_en,
    input logic [2:0]           op_code,
    input logic [CR_W-1:0]      cr_q
);

    function automatic logic [FIELD_W-1:0] grp_of(input logic [CR_W-1:0] v,
                                                  input logic [FLD_IW-1:0] g);
        return v[(CR_W - 1 - int'(g) * FIELD_W) -: FIELD_W];
    endfunction

    logic fld_win;
    logic cp_win;
    logic any_req;
    assign fld_win = fld_wr_en && !all_wr_en;
    assign cp_win  = cp_en && !all_wr_en && !fld_wr_en;
    assign any_req = all_wr_en || fld_wr_en || cp_en || (op_en && op_code != 3'd7);

    // R1: right after reset is released the word is zero
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> cr_q == '0);

    // R2 / R9: full load wins and lands whole
    p_full_load_r2: assert property (@(posedge clk) disable iff (rst)
        all_wr_en |=> cr_q == $past(all_wr_data));

    // R4: group write lands in the chosen group
    p_field_load_r4: assert property (@(posedge clk) disable iff (rst)
        fld_win |=> grp_of(cr_q, $past(fld_wr_sel)) == $past(fld_wr_flags));

    // R8: copy places the old source group in the destination
    p_copy_r8: assert property (@(posedge clk) disable iff (rst)
        cp_win |=> grp_of(cr_q, $past(cp_dst)) == grp_of($past(cr_q), $past(cp_src)));

    // R5: a lone bit operation changes at most one bit
    p_single_bit_r5: assert property (@(posedge clk) disable iff (rst)
        (op_en && !all_wr_en && !fld_wr_en && !cp_en) |=>
            $countones(cr_q ^ $past(cr_q)) <= 1);

    // R10 / R6: no effective request keeps the word
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !any_req |=> $stable(cr_q));

endmodule

bind cond_reg cond_reg_checker u_cond_reg_checker (
    .clk          (clk),
    .rst          (rst),
    .all_wr_en    (all_wr_en),
    .all_wr_data  (all_wr_data),
    .fld_wr_en    (fld_wr_en),
    .fld_wr_sel   (fld_wr_sel),
    .fld_wr_flags (fld_wr_flags),
    .cp_en        (cp_en),
    .cp_src       (cp_src),
    .cp_dst       (cp_dst),
    .op_en        (op_en),
    .op_code      (op_code),
    .cr_q         (cr_q)
);

// File: tb/cond_reg_bench.sv
`timescale 1ns/1ps
module cond_reg_bench;
    import cond_reg_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        all_wr_en;
    logic [31:0] all_wr_data;
    logic        fld_wr_en;
    logic [2:0]  fld_wr_sel;
    logic [3:0]  fld_wr_flags;
    logic        cp_en;
    logic [2:0]  cp_src;
    logic [2:0]  cp_dst;
    logic        op_en;
    logic [2:0]  op_code;
    logic [4:0]  op_src_a;
    logic [4:0]  op_src_b;
    logic [4:0]  op_dst;
    logic [31:0] cr_q;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    cond_reg u_cond_reg (.*);

    // Preload word: groups 0,2,4,6 all ones, groups 1,3,5,7 all zeros,
    // so flag index i is 1 exactly when (i/4) is even.
    localparam logic [31:0] PRE = 32'hF0F0_F0F0;

    // {op(3), a(5), b(5), d(5), expected result bit(1)}
    localparam int NV = 20;
    localparam logic [18:0] VEC [NV] = '{
        {3'd0, 5'd0,  5'd8,  5'd4,  1'b1},  // AND 1,1
        {3'd0, 5'd0,  5'd4,  5'd1,  1'b0},  // AND 1,0
        {3'd1, 5'd4,  5'd5,  5'd2,  1'b0},  // OR 0,0
        {3'd1, 5'd4,  5'd1,  5'd6,  1'b1},  // OR 0,1
        {3'd2, 5'd0,  5'd8,  5'd3,  1'b0},  // XOR 1,1
        {3'd2, 5'd0,  5'd12, 5'd13, 1'b1},  // XOR 1,0
        {3'd3, 5'd4,  5'd12, 5'd20, 1'b1},  // NOR 0,0
        {3'd3, 5'd0,  5'd4,  5'd9,  1'b0},  // NOR 1,0
        {3'd4, 5'd16, 5'd24, 5'd28, 1'b1},  // XNOR 1,1
        {3'd4, 5'd16, 5'd20, 5'd24, 1'b0},  // XNOR 1,0
        {3'd5, 5'd0,  5'd4,  5'd30, 1'b1},  // ANDC 1,0
        {3'd5, 5'd0,  5'd8,  5'd16, 1'b0},  // ANDC 1,1
        {3'd6, 5'd4,  5'd12, 5'd29, 1'b1},  // ORC 0,0
        {3'd6, 5'd4,  5'd8,  5'd17, 1'b0},  // ORC 0,1
        {3'd4, 5'd5,  5'd5,  5'd5,  1'b1},  // set idiom
        {3'd2, 5'd2,  5'd2,  5'd2,  1'b0},  // clear idiom
        {3'd1, 5'd0,  5'd0,  5'd31, 1'b1},  // copy idiom
        {3'd3, 5'd10, 5'd10, 5'd10, 1'b0},  // invert idiom
        {3'd0, 5'd0,  5'd4,  5'd0,  1'b0},  // dest is source A
        {3'd6, 5'd7,  5'd7,  5'd7,  1'b1}   // ORC same index
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        all_wr_en = 0; all_wr_data = '0;
        fld_wr_en = 0; fld_wr_sel = '0; fld_wr_flags = '0;
        cp_en = 0; cp_src = '0; cp_dst = '0;
        op_en = 0; op_code = '0; op_src_a = '0; op_src_b = '0; op_dst = '0;
    endtask

    // Requests set at a falling edge commit at the next rising edge;
    // the result is read at the following falling edge.
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic load(input logic [31:0] w);
        all_wr_en = 1; all_wr_data = w;
        step();
    endtask

    task automatic bitop(input logic [2:0] c, input logic [4:0] a,
                         input logic [4:0] b, input logic [4:0] d);
        op_en = 1; op_code = c; op_src_a = a; op_src_b = b; op_dst = d;
        step();
    endtask

    initial begin
        idle();
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        check("R1 reset value", cr_q, 32'h0);

        load(32'hDEAD_BEEF);
        check("R2 full load", cr_q, 32'hDEAD_BEEF);

        // Vector walk over the bit logic (R5, R7)
        for (int k = 0; k < NV; k++) begin
            logic [31:0] exp;
            load(PRE);
            bitop(VEC[k][18:16], VEC[k][15:11], VEC[k][10:6], VEC[k][5:1]);
            exp = PRE;
            exp[31 - int'(VEC[k][5:1])] = VEC[k][0];
            check($sformatf("R5/R7 vector %0d", k), cr_q, exp);
        end

        // R3: group 7 equal flag is index 30 = cr_q[1]
        load(32'h0);
        fld_wr_en = 1; fld_wr_sel = 3'd7; fld_wr_flags = 4'b0010;
        step();
        check("R3 group7 equal at bit position 1", cr_q, 32'h0000_0002);
        // R3: index 30 is also what the bit logic addresses
        bitop(3'd1, 5'd30, 5'd30, 5'd0);
        check("R3 index 30 copied to index 0", cr_q, 32'h8000_0002);

        // R4: group write touches one group only
        load(32'h1234_5678);
        fld_wr_en = 1; fld_wr_sel = 3'd2; fld_wr_flags = 4'hA;
        step();
        check("R4 group 2 write", cr_q, 32'h12A4_5678);

        // R8: copy group 1 to group 6
        cp_en = 1; cp_src = 3'd1; cp_dst = 3'd6;
        step();
        check("R8 copy 1 to 6", cr_q, 32'h12A4_5628);
        cp_en = 1; cp_src = 3'd3; cp_dst = 3'd3;
        step();
        check("R8 copy to itself", cr_q, 32'h12A4_5628);

        // R6: reserved code leaves the word
        bitop(3'd7, 5'd0, 5'd0, 5'd0);
        check("R6 code 7 no change", cr_q, 32'h12A4_5628);

        // R10: idle cycles hold
        step();
        step();
        check("R10 hold", cr_q, 32'h12A4_5628);

        // R9: priority
        all_wr_en = 1; all_wr_data = 32'h0F0F_0000;
        fld_wr_en = 1; fld_wr_sel = 3'd0; fld_wr_flags = 4'hF;
        cp_en = 1; cp_src = 3'd0; cp_dst = 3'd7;
        op_en = 1; op_code = 3'd4; op_src_a = 5'd31; op_src_b = 5'd31; op_dst = 5'd31;
        step();
        check("R9 full load wins", cr_q, 32'h0F0F_0000);
        fld_wr_en = 1; fld_wr_sel = 3'd7; fld_wr_flags = 4'h5;
        cp_en = 1; cp_src = 3'd1; cp_dst = 3'd7;
        op_en = 1; op_code = 3'd4; op_src_a = 5'd0; op_src_b = 5'd0; op_dst = 5'd0;
        step();
        check("R9 group write wins", cr_q, 32'h0F0F_0005);
        cp_en = 1; cp_src = 3'd1; cp_dst = 3'd4;
        op_en = 1; op_code = 3'd4; op_src_a = 5'd0; op_src_b = 5'd0; op_dst = 5'd0;
        step();
        check("R9 copy wins over bit op", cr_q, 32'h0F0F_F005);

        // R1: reset clears a loaded word
        rst = 1;
        step();
        rst = 0;
        check("R1 reset after use", cr_q, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule